// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Symbol Transmitter

This block drives a single-wire bus on which each symbol is a level held for a set number of clock cycles. A controller issues one command at a time: start-of-frame, a data byte, a CRC byte, end-of-data, end-of-frame or break. The block turns each command into timed active and passive levels. A data or CRC byte becomes eight bit symbols. Their level alternates from one bit to the next, and each bit's value is carried in how long that level is held.

Symbols follow one another with no idle cycle between them. `busy` drops during the final cycle of a command's last symbol. A command presented in that cycle therefore starts at the very edge where the previous symbol ends. `done` pulses once per finished command. `abort` returns the line to passive and the block to idle. The `invert` input sets the polarity of the physical pin relative to the logical bus level.

The symbol durations are parameters in clock cycles: short bit, long bit, frame delimiter, end-of-frame and break. The CRC value and the bus arbitration are supplied by neighbouring logic.

Top module: `vpw_sym_tx`

## Requirements
- R1: After reset, and whenever no command is running, the logical bus level is passive (0). `busy` is 0 and `done` is 0.
- R2: Command code 0 (start-of-frame) drives the bus active for TV3 (200) cycles. Code 5 (break) drives it active for TV5 (300) cycles.
- R3: Command code 3 (end-of-data) holds the bus passive for TV3 (200) cycles. Code 4 (end-of-frame) holds it passive for TV4 (280) cycles. When these two are sent back to back, they form one passive stretch of 480 cycles.
- R4: Command code 1 (data byte) sends eight bit symbols, most significant bit first. Bit k (k = 0 is the first) is passive for even k and active for odd k, so the byte starts passive and ends active. A zero bit lasts TV1 (64) cycles when passive and TV2 (128) cycles when active. A one bit lasts TV2 when passive and TV1 when active.
- R5: Command code 2 (CRC byte) produces exactly the same symbols as code 1 for the same byte value.
- R6: A command is accepted on the clock edge where `cmd_valid` is 1 and `busy` is 0. Its first symbol is visible on the bus right after that edge. A command accepted in the final cycle of the previous command follows it with no gap, and the level stays constant within a symbol.
- R7: `busy` is 1 while symbol time of the current command remains beyond the present cycle. A command presented while `busy` is 1 is ignored.
- R8: `done` is a one-cycle pulse in the cycle after a command's last symbol ends. It does not fire for an aborted command.
- R9: `abort` makes the bus passive, `busy` 0 and the block idle after the next clock edge, and the aborted command produces no `done`.
- R10: `bus_out` equals the logical bus level XOR `invert`, so with `invert` = 1 an idle bus reads 1.
- R11: Command codes 6 and 7 are ignored: nothing starts, and the bus stays passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; durations are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_kind | input | 3 | Command code (0 SOF, 1 data, 2 CRC, 3 EOD, 4 EOF, 5 break) |
| cmd_byte | input | 8 | Byte value for codes 1 and 2 |
| abort | input | 1 | Stop the current command and return to passive |
| invert | input | 1 | Invert the physical output polarity |
| bus_out | output | 1 | Physical bus drive level |
| busy | output | 1 | A new command cannot be accepted this cycle |
| done | output | 1 | One-cycle pulse when a command has finished |

## Verification
The hardest situation to reach is a command chained into the single cycle where `busy` has dropped and the previous symbol is still on the bus. A gap or an extra cycle there would be hidden inside a longer pulse. The driver waits at the falling edge for `busy` to go low and presents the next command right away, so every frame is a gap-free chain. The monitor measures each run of constant level and compares it exactly with the expected symbol lengths, merging adjacent passive symbols. The stimulus also includes a command presented in mid-byte while `busy` is high, an abort inside a byte, reserved codes, and the inverted polarity.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [2:0] {
    K_SOF  = 3'd0,
    K_DATA = 3'd1,
    K_CRC  = 3'd2,
    K_EOD  = 3'd3,
    K_EOF  = 3'd4,
    K_BRK  = 3'd5
  } sym_kind_e;

  localparam int unsigned BYTE_BITS = 8;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic kind_known(input logic [2:0] k);
    return (k <= 3'd5);
  endfunction

  function automatic logic kind_is_byte(input logic [2:0] k);
    return (k == K_DATA) || (k == K_CRC);
  endfunction

  // Bits are sent first-bit-passive, and the level alternates after that.
  function automatic logic bit_level(input logic [2:0] idx);
    return idx[0];
  endfunction

  // Zero bits favour a short passive or long active; one bits the opposite.
  function automatic logic bit_is_long(input logic bitv, input logic lvl);
    return bitv ^ lvl;
  endfunction

endpackage

// File: rtl/vpw_sym_plan.sv
module vpw_sym_plan
  import vpw_tx_pkg::*;
#(
  parameter int unsigned TV1 = 64,
  parameter int unsigned TV2 = 128,
  parameter int unsigned TV3 = 200,
  parameter int unsigned TV4 = 280,
  parameter int unsigned TV5 = 300,
  parameter int unsigned CW  = 9
) (
  input  logic [2:0]    kind,
  input  logic [7:0]    byte_val,
  input  logic [2:0]    idx,
  output logic          sym_lvl,
  output logic [CW-1:0] sym_len
);

  logic bitv;
  assign bitv = byte_val[3'd7 - idx];

  always_comb begin
    sym_lvl = 1'b0;
    sym_len = CW'(TV1);
    case (kind)
      K_SOF: begin sym_lvl = 1'b1; sym_len = CW'(TV3); end
      K_DATA, K_CRC: begin
        sym_lvl = bit_level(idx);
        sym_len = bit_is_long(bitv, bit_level(idx)) ? CW'(TV2) : CW'(TV1);
      end
      K_EOD: begin sym_lvl = 1'b0; sym_len = CW'(TV3); end
      K_EOF: begin sym_lvl = 1'b0; sym_len = CW'(TV4); end
      K_BRK: begin sym_lvl = 1'b1; sym_len = CW'(TV5); end
      default: begin sym_lvl = 1'b0; sym_len = CW'(TV1); end
    endcase
  end

endmodule

// File: rtl/vpw_dur_timer.sv
module vpw_dur_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear)         cnt_q <= '0;
    else if (load)          cnt_q <= load_len - CW'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/vpw_out_stage.sv
module vpw_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic set,
  input  logic set_lvl,
  input  logic invert,
  output logic lvl_q,
  output logic bus_out
);

  always_ff @(posedge clk) begin
    if (!rst_n)     lvl_q <= 1'b0;
    else if (set)   lvl_q <= set_lvl;
    else if (drop)  lvl_q <= 1'b0;
  end

  assign bus_out = lvl_q ^ invert;

endmodule

// File: rtl/vpw_sym_tx.sv
module vpw_sym_tx
  import vpw_tx_pkg::*;
#(
  parameter int unsigned TV1 = 64,
  parameter int unsigned TV2 = 128,
  parameter int unsigned TV3 = 200,
  parameter int unsigned TV4 = 280,
  parameter int unsigned TV5 = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_kind,
  input  logic [7:0] cmd_byte,
  input  logic       abort,
  input  logic       invert,
  output logic       bus_out,
  output logic       busy,
  output logic       done
);

  localparam int unsigned TV_MAX = max_u(max_u(max_u(TV1, TV2), max_u(TV3, TV4)), TV5);
  localparam int unsigned CW     = $clog2(TV_MAX + 1);

  // Named internal events, also observed by the bound checker.
  logic          running;
  logic [2:0]    kind_q;
  logic [7:0]    byte_q;
  logic [2:0]    idx_q;
  logic          t_expire;
  logic          sym_end;
  logic          last_sym;
  logic          fin_now;
  logic          start;
  logic          advance;
  logic          bus_lvl;
  logic [2:0]    plan_kind;
  logic [7:0]    plan_byte;
  logic [2:0]    plan_idx;
  logic          plan_lvl;
  logic [CW-1:0] plan_len;

  assign last_sym = !kind_is_byte(kind_q) || (idx_q == 3'(BYTE_BITS - 1));
  assign sym_end  = running && t_expire;
  assign fin_now  = sym_end && last_sym;
  assign busy     = running && !fin_now;
  assign start    = cmd_valid && !busy && kind_known(cmd_kind) && !abort;
  assign advance  = sym_end && !last_sym && !abort;

  assign plan_kind = start ? cmd_kind : kind_q;
  assign plan_byte = start ? cmd_byte : byte_q;
  assign plan_idx  = start ? 3'd0 : 3'(idx_q + 3'd1);

  vpw_sym_plan #(
    .TV1(TV1), .TV2(TV2), .TV3(TV3), .TV4(TV4), .TV5(TV5), .CW(CW)
  ) u_plan (
    .kind     (plan_kind),
    .byte_val (plan_byte),
    .idx      (plan_idx),
    .sym_lvl  (plan_lvl),
    .sym_len  (plan_len)
  );

  vpw_dur_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (abort),
    .load     (start || advance),
    .load_len (plan_len),
    .expire   (t_expire)
  );

  vpw_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .drop    (abort || (fin_now && !start)),
    .set     ((start || advance) && !abort),
    .set_lvl (plan_lvl),
    .invert  (invert),
    .lvl_q   (bus_lvl),
    .bus_out (bus_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      kind_q  <= 3'd0;
      byte_q  <= 8'd0;
      idx_q   <= 3'd0;
      done    <= 1'b0;
    end else begin
      done <= fin_now && !abort;
      if (abort) begin
        running <= 1'b0;
      end else if (start) begin
        running <= 1'b1;
        kind_q  <= cmd_kind;
        byte_q  <= cmd_byte;
        idx_q   <= 3'd0;
      end else if (advance) begin
        idx_q <= 3'(idx_q + 3'd1);
      end else if (fin_now) begin
        running <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vpw_sym_tx_chk.sv
module vpw_sym_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       abort,
  input logic       busy,
  input logic       done,
  input logic       running,
  input logic       sym_end,
  input logic       fin_now,
  input logic       start,
  input logic       bus_lvl,
  input logic [2:0] idx_q,
  input logic [2:0] kind_q
);

  p_idle_passive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !bus_lvl);

  p_sof_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && (cmd_kind == 3'd0) |=> bus_lvl);

  p_byte_ends_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running && ((kind_q == 3'd1) || (kind_q == 3'd2)) && (idx_q == 3'd7) |-> bus_lvl);

  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running && !sym_end && !abort |=> $stable(bus_lvl));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && !abort |=> running && $stable(kind_q));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_now && !abort |=> done);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !bus_lvl && !busy && !done);

  p_bad_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind > 3'd5) && !running |=> !running);

endmodule

bind vpw_sym_tx vpw_sym_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .abort     (abort),
  .busy      (busy),
  .done      (done),
  .running   (running),
  .sym_end   (sym_end),
  .fin_now   (fin_now),
  .start     (start),
  .bus_lvl   (bus_lvl),
  .idx_q     (idx_q),
  .kind_q    (kind_q)
);

// File: tb/vpw_sym_tx_bench.sv
module vpw_sym_tx_bench;

  localparam int S_TV1 = 64;
  localparam int S_TV2 = 128;
  localparam int S_TV3 = 200;
  localparam int S_TV4 = 280;
  localparam int S_TV5 = 300;
  localparam int WILD  = -1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_kind = 3'd0;
  logic [7:0] cmd_byte = 8'd0;
  logic       abort = 1'b0;
  logic       invert = 1'b0;
  logic       bus_out;
  logic       busy;
  logic       done;

  always #2 clk = ~clk;

  vpw_sym_tx u_vpw_sym_tx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_byte(cmd_byte), .abort(abort), .invert(invert),
    .bus_out(bus_out), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail = 0;
  int exp_done = 0;
  int seen_done = 0;
  bit finished = 0;

  bit    q_lvl[$];
  int    q_len[$];
  string q_tag[$];
  bit    p_valid = 0;
  bit    p_lvl;
  int    p_len;
  string p_tag;

  bit mon_en = 0;
  bit m_started = 0;
  bit m_lvl;
  int m_len;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected runs of constant level; adjacent equal levels merge into one run.
  task automatic push_seg(input bit lvl, input int len, input string tag);
    if (p_valid && p_lvl == lvl) begin
      if (p_len != WILD) p_len = (len == WILD) ? WILD : p_len + len;
    end else begin
      if (p_valid) begin
        q_lvl.push_back(p_lvl); q_len.push_back(p_len); q_tag.push_back(p_tag);
      end
      p_valid = 1; p_lvl = lvl; p_len = len; p_tag = tag;
    end
  endtask

  task automatic expect_cmd(input int kind, input logic [7:0] b);
    case (kind)
      0: push_seg(1'b1, S_TV3, "R2 sof");
      3: push_seg(1'b0, S_TV3, "R3 eod");
      4: push_seg(1'b0, S_TV4, "R3 eof");
      5: push_seg(1'b1, S_TV5, "R2 break");
      default: begin
        for (int i = 0; i < 8; i++) begin
          bit bv;
          bit lv;
          int ln;
          bv = b[7 - i];
          lv = (i % 2) == 1;
          if (!lv) ln = bv ? S_TV2 : S_TV1;
          else     ln = bv ? S_TV1 : S_TV2;
          push_seg(lv, ln, (kind == 2) ? "R5 crc bit" : "R4 data bit");
        end
      end
    endcase
  endtask

  task automatic issue(input int kind, input logic [7:0] b);
    bit was_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    was_idle = !u_vpw_sym_tx.busy && !p_valid ? 1'b1 : 1'b0;
    if (mon_en) expect_cmd(kind, b);
    exp_done++;
    cmd_valid = 1'b1; cmd_kind = 3'(kind); cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (kind == 0 || kind == 5)
      check((bus_out ^ invert) == 1'b1, "R6 first symbol right after accept", int'(bus_out ^ invert), 1);
    if (was_idle) check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
  endtask

  task automatic end_frame();
    if (mon_en) push_seg(1'b0, WILD, "R1 idle");
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1 idle busy", int'(busy), 0);
    check((bus_out ^ invert) == 1'b0, "R1 idle passive", int'(bus_out ^ invert), 0);
  endtask

  // Monitor: measure each run of constant logical level and score it.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) seen_done++;
      if (!mon_en) begin
        m_started = 0;
      end else begin
        bit l;
        l = bus_out ^ invert;
        if (!m_started) begin
          m_started = 1; m_lvl = l; m_len = 1;
        end else if (l != m_lvl) begin
          if (q_lvl.size() == 0) begin
            check(0, "R6 unexpected run", m_len, 0);
          end else begin
            bit el; int en; string et;
            el = q_lvl.pop_front(); en = q_len.pop_front(); et = q_tag.pop_front();
            check(el == m_lvl, {et, " level"}, int'(m_lvl), int'(el));
            if (en != WILD) check(en == m_len, {et, " length"}, m_len, en);
          end
          m_lvl = l; m_len = 1;
        end else begin
          m_len++;
        end
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_out == 1'b0, "R1 reset bus passive", int'(bus_out), 0);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);

    // Frame with data and CRC chained without gaps.
    p_valid = 0;
    push_seg(1'b0, WILD, "R1 idle");
    mon_en = 1;
    issue(0, 8'h00);
    issue(1, 8'hA5);
    issue(2, 8'h3C);
    issue(3, 8'h00);
    issue(4, 8'h00);
    end_frame();

    // Break, then all-zero and all-one bytes, with a command tried mid-byte.
    issue(5, 8'h00);
    issue(0, 8'h00);
    issue(1, 8'h00);
    issue(1, 8'hFF);
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R7 busy mid byte", int'(busy), 1);
    cmd_valid = 1'b1; cmd_kind = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    issue(2, 8'h5A);
    issue(3, 8'h00);
    issue(4, 8'h00);
    end_frame();

    // Inverted polarity.
    invert = 1'b1;
    @(negedge clk);
    check(bus_out == 1'b1, "R10 idle inverted", int'(bus_out), 1);
    issue(0, 8'h00);
    issue(1, 8'h96);
    issue(3, 8'h00);
    end_frame();
    invert = 1'b0;

    // Reserved codes.
    for (int k = 6; k < 8; k++) begin
      int d0;
      d0 = seen_done;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_kind = 3'(k);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R11 reserved code busy", int'(busy), 0);
      check(bus_out == 1'b0, "R11 reserved code bus", int'(bus_out), 0);
      check(seen_done == d0, "R11 reserved code done", seen_done - d0, 0);
    end

    // Abort in the middle of a byte.
    mon_en = 0;
    issue(0, 8'h00);
    issue(1, 8'hF0);
    exp_done--;
    repeat (30) @(negedge clk);
    begin
      int d0;
      d0 = seen_done;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check(bus_out == 1'b0, "R9 abort passive", int'(bus_out), 0);
      check(busy == 1'b0, "R9 abort busy", int'(busy), 0);
      repeat (300) @(negedge clk);
      check(seen_done == d0, "R9 abort no done", seen_done - d0, 0);
      check(bus_out == 1'b0, "R9 stays passive", int'(bus_out), 0);
    end

    // Recovery after abort.
    q_lvl.delete(); q_len.delete(); q_tag.delete();
    p_valid = 0;
    push_seg(1'b0, WILD, "R1 idle");
    mon_en = 1;
    issue(0, 8'h00);
    issue(2, 8'h81);
    issue(3, 8'h00);
    end_frame();

    repeat (5) @(negedge clk);
    check(seen_done == exp_done, "R8 done pulse count", seen_done, exp_done);
    check(q_lvl.size() == 0, "R6 all runs observed", q_lvl.size(), 0);
    report();
  end

endmodule